// File: doc/BRIEF.md
# Gated Prescaled 16-bit Timer

This block is a 16-bit up-counter driven through a small synchronous register port. It has two clock sources. The first is the system clock, which acts as the instruction-rate clock. The second is the rising edges of an external input, which can pass through a two-flop synchronizer or through a shorter single-stage detector. Before reaching the counter, either source goes through a prescaler with ratios 1, 8, 64 or 256.

With the internal source, a gated accumulation mode is available. In this mode the counter advances only while a gate input is high, and the end of each gate pulse raises the interrupt flag. In normal operation the counter wraps to zero after it matches a programmable period. Each match sets a sticky flag and produces a one-cycle interrupt pulse. A stop-in-idle option freezes counting while an idle input is asserted.

Software programs the control, count, period and status words through a 2-bit address. It then watches the flag output, or polls the status word.

Top module: `gated_timer16`

## Requirements
- R1: After reset the control, count, period and status words all read 0, and both interrupt outputs are low.
- R2: The control word implements only bits 15 (enable), 13 (idle stop), 6 (gate enable), 5:4 (prescale select), 2 (sync enable) and 1 (source, 1 = external). Writing 0xFFFF reads back 0xA076. Addresses are 0 control, 1 count, 2 period, 3 status (bit 0 = flag).
- R3: With bit 15 at 1 the counter advances; with it at 0 the count holds. A control write produces no count tick in its own cycle.
- R4: Prescale select 00/01/10/11 gives one count every 1/8/64/256 source ticks. The first count lands exactly on the 8th, 64th or 256th tick after the enabling write.
- R5: Every control write clears the prescaler, so a rewritten ratio restarts from a full count.
- R6: A tick that finds the count equal to a non-zero period loads 0, sets the flag and pulses the interrupt output for exactly one cycle.
- R7: A period of 0 never matches. The count wraps from 0xFFFF to 0 with no flag.
- R8: Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged. A pulse always leaves the flag set.
- R9: With bit 13 at 1 an asserted idle input freezes the count. With bit 13 at 0 the idle input has no effect.
- R10: In gated mode (bit 6 = 1, internal source) the count advances only on cycles where the gate is high. A period match sets no flag. The first cycle after the gate falls sets the flag and pulses the interrupt.
- R11: With the external source selected, the gate enable and gate input have no effect on counting or on the flag.
- R12: Each external rising edge counts once. The count changes on the third clock edge after the input rises when synchronised, and on the second edge when not.
- R13: The sync enable bit has no effect while the internal source is selected.
- R14: A software write to the count word takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select (0 control, 1 count, 2 period, 3 status) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register, combinational |
| ext_clk_i | input | 1 | External count input, rising edges counted |
| gate_i | input | 1 | Gate for accumulation mode, synchronous to clk |
| idle_i | input | 1 | Idle request, synchronous to clk |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that gate_i and idle_i are synchronous to clk, since they relate the count in one cycle to the level of those inputs in the previous cycle. The stimulus meets this by changing gate, idle, external clock and bus signals only on falling clock edges. It also keeps the external input low whenever the source is switched, and it never changes the mode in the cycle right after a period match, so no interrupt pulse comes from a mode change.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int BIT_EN        = 15;
    localparam int BIT_IDLE_STOP = 13;
    localparam int BIT_GATE      = 6;
    localparam int BIT_PS_HI     = 5;
    localparam int BIT_PS_LO     = 4;
    localparam int BIT_SYNC      = 2;
    localparam int BIT_SRC       = 1;

    typedef struct packed {
        logic       en;
        logic       idle_stop;
        logic       gate_en;
        logic [1:0] ps;
        logic       sync_en;
        logic       src_ext;
    } ctrl_t;

endpackage

// File: rtl/gtmr_edge_detect.sv
module gtmr_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic sync_en_i,
    output logic rise_o
);

    localparam int SR_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SR_W-1:0] stg;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stg = {st_q.stg[SR_W-2:0], sig_i};
        if (sync_en_i) begin
            rise_o = st_q.stg[SYNC_STAGES-1] & ~st_q.stg[SYNC_STAGES];
        end else begin
            rise_o = st_q.stg[0] & ~st_q.stg[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } ps_state_t;

    ps_state_t        st_d, st_q;
    logic [DIV_W-1:0] term;

    always_comb begin
        case (sel_i)
            2'd0:    term = '0;
            2'd1:    term = DIV_W'(7);
            2'd2:    term = DIV_W'(63);
            default: term = DIV_W'(255);
        endcase
    end

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == term) begin
                st_d.cnt = '0;
                tick_o   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              ext_clk_i,
    input  logic              gate_i,
    input  logic              idle_i,
    output logic              irq_pulse_o,
    output logic              irq_flag_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] period;
        logic              flag;
        logic              pulse;
        logic              gate_d;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic wr_ctrl, wr_count, wr_period, wr_status;
    logic run, gated, base_tick, ps_clear, cnt_tick, ext_rise;
    logic match, gate_fall, set_flag;

    gtmr_edge_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_i     (ext_clk_i),
        .sync_en_i (st_q.ctrl.sync_en),
        .rise_o    (ext_rise)
    );

    gtmr_prescaler #(
        .DIV_W (DIV_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ps_clear),
        .tick_i  (base_tick),
        .sel_i   (st_q.ctrl.ps),
        .tick_o  (cnt_tick)
    );

    // decode and tick sources
    always_comb begin
        wr_ctrl   = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_CTRL);
        wr_count  = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_COUNT);
        wr_period = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_PERIOD);
        wr_status = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_STATUS);

        run   = st_q.ctrl.en && !(st_q.ctrl.idle_stop && idle_i);
        gated = st_q.ctrl.gate_en && !st_q.ctrl.src_ext;

        if (st_q.ctrl.src_ext) begin
            base_tick = run && ext_rise;
        end else if (gated) begin
            base_tick = run && gate_i;
        end else begin
            base_tick = run;
        end
        ps_clear = wr_ctrl || !st_q.ctrl.en;
    end

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.gate_d = gate_i;

        match     = cnt_tick && !wr_count && (st_q.period != '0)
                    && (st_q.count == st_q.period);
        gate_fall = gated && run && st_q.gate_d && !gate_i;
        set_flag  = (match && !gated) || gate_fall;

        if (wr_ctrl) begin
            st_d.ctrl.en        = bus_wdata_i[BIT_EN];
            st_d.ctrl.idle_stop = bus_wdata_i[BIT_IDLE_STOP];
            st_d.ctrl.gate_en   = bus_wdata_i[BIT_GATE];
            st_d.ctrl.ps        = bus_wdata_i[BIT_PS_HI:BIT_PS_LO];
            st_d.ctrl.sync_en   = bus_wdata_i[BIT_SYNC];
            st_d.ctrl.src_ext   = bus_wdata_i[BIT_SRC];
        end

        if (wr_period) begin
            st_d.period = bus_wdata_i;
        end

        if (wr_count) begin
            st_d.count = bus_wdata_i;
        end else if (cnt_tick) begin
            st_d.count = match ? '0 : st_q.count + DATA_W'(1);
        end

        if (wr_status && !bus_wdata_i[0]) begin
            st_d.flag = 1'b0;
        end
        if (set_flag) begin
            st_d.flag = 1'b1;
        end
        st_d.pulse = set_flag;
    end

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        case (reg_sel_e'(bus_addr_i))
            REG_CTRL: begin
                bus_rdata_o[BIT_EN]              = st_q.ctrl.en;
                bus_rdata_o[BIT_IDLE_STOP]       = st_q.ctrl.idle_stop;
                bus_rdata_o[BIT_GATE]            = st_q.ctrl.gate_en;
                bus_rdata_o[BIT_PS_HI:BIT_PS_LO] = st_q.ctrl.ps;
                bus_rdata_o[BIT_SYNC]            = st_q.ctrl.sync_en;
                bus_rdata_o[BIT_SRC]             = st_q.ctrl.src_ext;
            end
            REG_COUNT:  bus_rdata_o = st_q.count;
            REG_PERIOD: bus_rdata_o = st_q.period;
            default:    bus_rdata_o[0] = st_q.flag;
        endcase
    end

    assign irq_pulse_o = st_q.pulse;
    assign irq_flag_o  = st_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
    import gtmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              gate,
    input logic              idle,
    input logic              ctrl_en,
    input logic              ctrl_idle_stop,
    input logic              ctrl_gate_en,
    input logic              ctrl_src_ext,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] period,
    input logic              flag,
    input logic              pulse
);

    logic cnt_wr;
    assign cnt_wr = bus_wr && (reg_sel_e'(bus_addr) == REG_COUNT);

    // R3: a stopped timer holds its count
    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !cnt_wr) |=> $stable(count));

    // R9: idle with idle stop freezes the count
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_idle_stop && idle && !cnt_wr) |=> $stable(count));

    // R10: gated mode with gate low accumulates nothing
    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_gate_en && !ctrl_src_ext && !gate && !cnt_wr) |=> $stable(count));

    // R8: every interrupt pulse leaves the flag set
    assert_pulse_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);

    // R7: a zero period outside gated mode never pulses
    assert_zero_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((period == '0) && !(ctrl_gate_en && !ctrl_src_ext)) |=> !pulse);

endmodule

bind gated_timer16 gtmr_checker u_gtmr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr_i),
    .bus_addr       (bus_addr_i),
    .gate           (gate_i),
    .idle           (idle_i),
    .ctrl_en        (st_q.ctrl.en),
    .ctrl_idle_stop (st_q.ctrl.idle_stop),
    .ctrl_gate_en   (st_q.ctrl.gate_en),
    .ctrl_src_ext   (st_q.ctrl.src_ext),
    .count          (st_q.count),
    .period         (st_q.period),
    .flag           (st_q.flag),
    .pulse          (st_q.pulse)
);

// File: tb/test_gated_timer16.sv
module test_gated_timer16;
    import gtmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic        gate = 1'b0;
    logic        idle = 1'b0;
    logic        irq_pulse;
    logic        irq_flag;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_PER  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    always #10 clk = ~clk;

    gated_timer16 i_gated_timer16 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .ext_clk_i   (ext_clk),
        .gate_i      (gate),
        .idle_i      (idle),
        .irq_pulse_o (irq_pulse),
        .irq_flag_o  (irq_flag)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiesce();
        wr(A_CTRL, 16'h0000);
        wr(A_CNT, 16'h0000);
        wr(A_PER, 16'h0000);
        wr(A_STAT, 16'h0000);
    endtask

    task automatic t_reset();
        rd(A_CTRL, 16'h0, "R1 ctrl");
        rd(A_CNT, 16'h0, "R1 count");
        rd(A_PER, 16'h0, "R1 period");
        rd(A_STAT, 16'h0, "R1 status");
        chk("R1 irq outputs", {14'h0, irq_pulse, irq_flag}, 16'h0);
    endtask

    task automatic t_mask();
        wr(A_CTRL, 16'hFFFF);
        rd(A_CTRL, 16'hA076, "R2 unimplemented bits");
        quiesce();
    endtask

    task automatic t_enable();
        wr(A_CTRL, 16'h8000);
        step(10);
        rd(A_CNT, 16'd10, "R3 running count");
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, 16'd10, "R3 no tick on control write");
        step(10);
        rd(A_CNT, 16'd10, "R3 stopped hold");
        quiesce();
    endtask

    task automatic t_prescale();
        wr(A_CTRL, 16'h8010);
        step(15);
        rd(A_CNT, 16'd1, "R4 1:8 before");
        step(1);
        rd(A_CNT, 16'd2, "R4 1:8 boundary");
        quiesce();
        wr(A_CTRL, 16'h8020);
        step(127);
        rd(A_CNT, 16'd1, "R4 1:64 before");
        step(1);
        rd(A_CNT, 16'd2, "R4 1:64 boundary");
        quiesce();
        wr(A_CTRL, 16'h8030);
        step(511);
        rd(A_CNT, 16'd1, "R4 1:256 before");
        step(1);
        rd(A_CNT, 16'd2, "R4 1:256 boundary");
        quiesce();
    endtask

    task automatic t_presc_clear();
        wr(A_CTRL, 16'h8010);
        step(5);
        wr(A_CTRL, 16'h8010);
        step(7);
        rd(A_CNT, 16'd0, "R5 prescaler restarted");
        step(1);
        rd(A_CNT, 16'd1, "R5 full ratio after rewrite");
        quiesce();
    endtask

    task automatic t_period();
        wr(A_PER, 16'd4);
        wr(A_CTRL, 16'h8000);
        step(4);
        rd(A_CNT, 16'd4, "R6 reaches period");
        rd(A_STAT, 16'd0, "R6 no flag before match");
        step(1);
        rd(A_CNT, 16'd0, "R6 wraps to zero");
        rd(A_STAT, 16'd1, "R6 flag set");
        chk("R6 pulse high", {15'h0, irq_pulse}, 16'd1);
        step(1);
        chk("R6 pulse one cycle", {15'h0, irq_pulse}, 16'd0);
        rd(A_CNT, 16'd1, "R6 counts on");
        // R8: flag clearing rules
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, 16'd1, "R8 writing one keeps flag");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'd0, "R8 writing zero clears");
        wr(A_STAT, 16'h0001);
        rd(A_STAT, 16'd0, "R8 writing one does not set");
        quiesce();
    endtask

    task automatic t_period_zero();
        wr(A_CNT, 16'hFFFE);
        wr(A_CTRL, 16'h8000);
        step(3);
        rd(A_CNT, 16'd1, "R7 wrap through FFFF");
        rd(A_STAT, 16'd0, "R7 no flag at zero period");
        chk("R7 flag output", {15'h0, irq_flag}, 16'd0);
        quiesce();
    endtask

    task automatic t_count_write();
        wr(A_CTRL, 16'h8000);
        step(3);
        wr(A_CNT, 16'h1234);
        rd(A_CNT, 16'h1234, "R14 write beats tick");
        step(1);
        rd(A_CNT, 16'h1235, "R14 counts from written value");
        quiesce();
    endtask

    task automatic t_idle();
        idle = 1'b1;
        wr(A_CTRL, 16'hA000);
        step(10);
        rd(A_CNT, 16'd0, "R9 frozen in idle");
        idle = 1'b0;
        step(5);
        rd(A_CNT, 16'd5, "R9 resumes");
        idle = 1'b1;
        wr(A_CTRL, 16'h8000);
        step(5);
        rd(A_CNT, 16'd10, "R9 idle ignored without stop bit");
        idle = 1'b0;
        quiesce();
    endtask

    task automatic t_gated();
        wr(A_PER, 16'd3);
        wr(A_CTRL, 16'h8040);
        step(5);
        rd(A_CNT, 16'd0, "R10 gate low no count");
        gate = 1'b1;
        step(6);
        rd(A_CNT, 16'd2, "R10 accumulates with wrap");
        rd(A_STAT, 16'd0, "R10 no flag on period match");
        gate = 1'b0;
        step(1);
        rd(A_STAT, 16'd1, "R10 flag on gate fall");
        chk("R10 pulse on gate fall", {15'h0, irq_pulse}, 16'd1);
        step(5);
        rd(A_CNT, 16'd2, "R10 holds after gate");
        quiesce();
    endtask

    task automatic t_ext();
        wr(A_CTRL, 16'h8006);
        ext_clk = 1'b1;
        step(2);
        rd(A_CNT, 16'd0, "R12 sync latency not yet");
        step(1);
        rd(A_CNT, 16'd1, "R12 sync edge counted");
        step(3);
        rd(A_CNT, 16'd1, "R12 high level counts once");
        ext_clk = 1'b0;
        step(4);
        quiesce();
        wr(A_CTRL, 16'h8002);
        ext_clk = 1'b1;
        step(1);
        rd(A_CNT, 16'd0, "R12 unsync latency not yet");
        step(1);
        rd(A_CNT, 16'd1, "R12 unsync edge counted");
        ext_clk = 1'b0;
        step(3);
        for (int i = 0; i < 4; i++) begin
            ext_clk = 1'b1; step(3);
            ext_clk = 1'b0; step(3);
        end
        rd(A_CNT, 16'd5, "R12 pulse train");
        quiesce();
    endtask

    task automatic t_gate_ignored();
        wr(A_CTRL, 16'h8042);
        for (int i = 0; i < 3; i++) begin
            ext_clk = 1'b1; step(3);
            ext_clk = 1'b0; step(3);
        end
        rd(A_CNT, 16'd3, "R11 ext counts with gate low");
        gate = 1'b1;
        step(3);
        gate = 1'b0;
        step(2);
        rd(A_STAT, 16'd0, "R11 gate fall ignored");
        quiesce();
    endtask

    task automatic t_sync_ignored();
        wr(A_CTRL, 16'h8004);
        step(10);
        rd(A_CNT, 16'd10, "R13 sync bit ignored internal");
        quiesce();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mask();
        t_enable();
        t_prescale();
        t_presc_clear();
        t_period();
        t_period_zero();
        t_count_write();
        t_idle();
        t_gated();
        t_ext();
        t_gate_ignored();
        t_sync_ignored();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule